// File: doc/BRIEF.md
# Multichannel ADC Serial Capture Controller

This block is the host side of a three-wire serial link to a simultaneous-sampling converter. From the system clock it makes a gated serial clock, fires a conversion-start pulse one serial-clock period wide, and then runs a fixed window of 96 serial-clock rising edges. Data begins after the third rising edge of that window. Up to six 14-bit channel words are shifted in, most significant bit first, and shown together on a wide parallel bus with a one-cycle valid strobe. While `runEn` is high, frames repeat at a rate set by a programmable idle gap.

The converter is put into its two low-power states with nothing but conversion-start pulses, while the serial clock is held quiet. Two pulses select the light state and four select the deep state. A single serial-clock pulse wakes it. After a deep-state wake the controller holds off for a programmable settle time before the converter counts as active again. This gives the converter's reference time to recover.

A mode request asks for one of these sequences. The controller takes a request only while it is idle. A busy output marks every frame and every power sequence.

Top module: `adc_capture_ctrl`

## Requirements
- R1: `adcSck` rests low whenever the controller is idle. During a frame its period is 2*SCK_HALF system clocks. `adcConv` rises while `adcSck` is low and stays high for exactly 2*SCK_HALF system clocks.
- R2: Each frame gives exactly FRAME_EDGES (96) rising edges on `adcSck` after `adcConv` rises. `adcConv` does not rise again inside that window.
- R3: Bit k of the frame (k = 0, 1, ...) is the `adcSdo` level that follows rising edge 3+k. It is sampled when `adcSck` falls. Words arrive channel 0 first, MSB first, and channel c appears on `chData[14c+13:14c]`.
- R4: `numCh` sets the number of captured words: 0 counts as 1 and values above 6 count as 6. Channels at or above that count read as zero in `chData`. Any `adcSdo` bits after the last word are discarded.
- R5: `dataValid` pulses for one cycle once per frame, when the last requested word has been captured. `chData` changes only in that cycle and holds until the next such pulse.
- R6: With `runEn` held high, consecutive `adcConv` rises are 192*SCK_HALF + max(`frameGap`, CONV_LOW_MIN) + 1 system clocks apart.
- R7: A request with `modeSel`=1 (nap) while active sends two `adcConv` pulses with no `adcSck` edge. After that `pwrState` reads 1.
- R8: A request with `modeSel`=2 (sleep) while active sends four `adcConv` pulses with no `adcSck` edge. After that `pwrState` reads 2.
- R9: Between power-down pulses `adcConv` stays low for max(2*SCK_HALF, CONV_LOW_MIN) system clocks, and never for fewer than CONV_LOW_MIN.
- R10: A request with `modeSel`=0 while in nap or sleep sends one `adcSck` pulse and no `adcConv` pulse. From nap, `pwrState` reads 0 on the 2*SCK_HALF+1-th falling clock edge after the request is sampled.
- R11: After a sleep wake, `pwrState` reads 0 only once `settleCycles` further system clocks have passed. A value of 0 selects SETTLE_DEFAULT.
- R12: `busy` is high throughout frames and power sequences. A `modeReq` that arrives while `busy` is high is ignored.
- R13: These requests change no pin and no state: a request for the state already in force, a nap or sleep request made while not active, or `modeSel`=3. While not active, `runEn` starts no frame.
- R14: After reset `adcConv`, `adcSck`, `busy` and `dataValid` are low, `chData` is zero and `pwrState` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Run frames back to back while active |
| frameGap | input | GAP_W | Idle system clocks between frames (floored at CONV_LOW_MIN) |
| numCh | input | 3 | Channels to capture, 1 to 6 |
| modeReq | input | 1 | One-cycle power mode request |
| modeSel | input | 2 | Requested mode: 0 active, 1 nap, 2 sleep |
| settleCycles | input | SETTLE_W | Wait after a sleep wake, 0 = SETTLE_DEFAULT |
| adcSdo | input | 1 | Serial data from the converter |
| adcConv | output | 1 | Conversion start to the converter |
| adcSck | output | 1 | Serial clock to the converter |
| chData | output | MAX_CH*WORD_BITS | Captured words, channel 0 in the low bits |
| dataValid | output | 1 | One-cycle strobe for a new set of words |
| busy | output | 1 | Frame or power sequence in progress |
| pwrState | output | 2 | Converter state: 0 active, 1 nap, 2 sleep |

## Verification
The assertions assume the following about the inputs. `modeReq` is a single-cycle pulse. `frameGap`, `numCh` and `settleCycles` hold steady while `busy` is high. `adcSdo` changes only right after an `adcSck` rise, so it is settled by the falling edge. The bench includes a converter model that updates `adcSdo` half a system clock after each serial-clock rise it observes. The bench changes the configuration inputs only after it has waited for `busy` to drop. Every mode request it issues lasts one cycle and falls on a falling clock edge.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

  // Power state reported to the host; values are visible on pwrState.
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_PD_HI,
    ST_PD_LO,
    ST_WAKE_HI,
    ST_WAKE_LO,
    ST_SETTLE
  } ctrlState_e;

  // Strobes from sequencer to capture datapath.
  typedef struct packed {
    logic frameStart;
    logic sampleBit;
  } ctrlStrobe_t;

  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;

endpackage

// File: rtl/adcc_ctrl.sv
module adcc_ctrl
  import adcc_pkg::*;
#(
  parameter int SCK_HALF       = 2,
  parameter int CONV_LOW_MIN   = 4,
  parameter int FRAME_EDGES    = 96,
  parameter int FIRST_EDGE     = 3,
  parameter int WORD_BITS      = 14,
  parameter int MAX_CH         = 6,
  parameter int GAP_W          = 16,
  parameter int SETTLE_W       = 20,
  parameter int SETTLE_DEFAULT = 500000,
  localparam int CH_W          = $clog2(MAX_CH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic [GAP_W-1:0]    frameGap,
  input  logic [CH_W-1:0]     numCh,
  input  logic                modeReq,
  input  logic [1:0]          modeSel,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                convOut,
  output logic                sckOut,
  output logic                busy,
  output pwr_e                pwrState,
  output logic [CH_W-1:0]     numChLat,
  output ctrlStrobe_t         strb
);

  localparam int EDGE_W  = $clog2(FRAME_EDGES + 1);
  localparam int BASE_W  = (SETTLE_W > GAP_W) ? SETTLE_W : GAP_W;
  localparam int TMR_W   = (BASE_W > 8) ? BASE_W + 1 : 9;
  localparam int LOW_LEN = (2 * SCK_HALF > CONV_LOW_MIN) ? 2 * SCK_HALF : CONV_LOW_MIN;

  ctrlState_e        state;
  pwr_e              pwrReg;
  pwr_e              pdTarget;
  logic [TMR_W-1:0]  tmr;
  logic [EDGE_W-1:0] edgeCnt;
  logic [2:0]        pulseCnt;
  logic              wasSleep;
  logic              convReg;
  logic              sckReg;

  logic              halfDone;
  logic              fallNow;
  logic              wakeReq;
  logic              pdReq;
  logic              startFrame;
  logic [EDGE_W-1:0] dataEnd;
  logic [TMR_W-1:0]  gapLen;
  logic [TMR_W-1:0]  settleLen;
  logic [2:0]        pulseTarget;
  logic [CH_W-1:0]   numChEff;

  always_comb begin
    halfDone    = (tmr == TMR_W'(SCK_HALF - 1));
    fallNow     = (state == ST_FRAME) && halfDone && sckReg;
    wakeReq     = (state == ST_IDLE) && modeReq && (pwr_e'(modeSel) == PWR_ACTIVE)
                  && (pwrReg != PWR_ACTIVE);
    pdReq       = (state == ST_IDLE) && modeReq && (pwrReg == PWR_ACTIVE)
                  && ((pwr_e'(modeSel) == PWR_NAP) || (pwr_e'(modeSel) == PWR_SLEEP));
    startFrame  = (state == ST_IDLE) && !wakeReq && !pdReq && runEn
                  && (pwrReg == PWR_ACTIVE);
    dataEnd     = EDGE_W'(FIRST_EDGE) + EDGE_W'(numChLat) * EDGE_W'(WORD_BITS);
    gapLen      = (frameGap < GAP_W'(CONV_LOW_MIN)) ? TMR_W'(CONV_LOW_MIN) : TMR_W'(frameGap);
    settleLen   = (settleCycles == '0) ? TMR_W'(SETTLE_DEFAULT) : TMR_W'(settleCycles);
    pulseTarget = (pdTarget == PWR_NAP) ? 3'(NAP_PULSES) : 3'(SLEEP_PULSES);
    if (numCh == '0)                      numChEff = CH_W'(1);
    else if (numCh > CH_W'(MAX_CH))       numChEff = CH_W'(MAX_CH);
    else                                  numChEff = numCh;
    strb.frameStart = startFrame;
    strb.sampleBit  = fallNow && (edgeCnt >= EDGE_W'(FIRST_EDGE)) && (edgeCnt < dataEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pwrReg   <= PWR_ACTIVE;
      pdTarget <= PWR_NAP;
      tmr      <= '0;
      edgeCnt  <= '0;
      pulseCnt <= '0;
      wasSleep <= 1'b0;
      convReg  <= 1'b0;
      sckReg   <= 1'b0;
      numChLat <= CH_W'(1);
    end else begin
      case (state)
        ST_IDLE: begin
          tmr <= '0;
          if (wakeReq) begin
            state    <= ST_WAKE_HI;
            sckReg   <= 1'b1;
            wasSleep <= (pwrReg == PWR_SLEEP);
          end else if (pdReq) begin
            state    <= ST_PD_HI;
            convReg  <= 1'b1;
            pulseCnt <= '0;
            pdTarget <= pwr_e'(modeSel);
          end else if (startFrame) begin
            state    <= ST_FRAME;
            convReg  <= 1'b1;
            sckReg   <= 1'b0;
            edgeCnt  <= '0;
            numChLat <= numChEff;
          end
        end
        ST_FRAME: begin
          if (halfDone) begin
            tmr    <= '0;
            sckReg <= ~sckReg;
            if (!sckReg) begin
              edgeCnt <= edgeCnt + 1'b1;
            end else begin
              if (edgeCnt == EDGE_W'(1)) convReg <= 1'b0;
              if (edgeCnt == EDGE_W'(FRAME_EDGES)) state <= ST_GAP;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == gapLen - 1'b1) begin
            state <= ST_IDLE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PD_HI: begin
          if (tmr == TMR_W'(2 * SCK_HALF - 1)) begin
            state   <= ST_PD_LO;
            convReg <= 1'b0;
            tmr     <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PD_LO: begin
          if (tmr == TMR_W'(LOW_LEN - 1)) begin
            tmr <= '0;
            if (pulseCnt == pulseTarget - 1'b1) begin
              state  <= ST_IDLE;
              pwrReg <= pdTarget;
            end else begin
              pulseCnt <= pulseCnt + 1'b1;
              state    <= ST_PD_HI;
              convReg  <= 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAKE_HI: begin
          if (halfDone) begin
            state  <= ST_WAKE_LO;
            sckReg <= 1'b0;
            tmr    <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAKE_LO: begin
          if (halfDone) begin
            tmr <= '0;
            if (wasSleep) begin
              state <= ST_SETTLE;
            end else begin
              state  <= ST_IDLE;
              pwrReg <= PWR_ACTIVE;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tmr == settleLen - 1'b1) begin
            state  <= ST_IDLE;
            pwrReg <= PWR_ACTIVE;
            tmr    <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convOut  = convReg;
  assign sckOut   = sckReg;
  assign busy     = (state != ST_IDLE);
  assign pwrState = pwrReg;

  // R2
  frame_no_reconv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAME && $past(state) == ST_FRAME) |-> !$rose(convOut));

  // R2
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_W'(FRAME_EDGES));

  // R7
  pd_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PD_HI || state == ST_PD_LO) |-> !sckOut);

  // R10
  wake_conv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE_HI || state == ST_WAKE_LO || state == ST_SETTLE) |-> !convOut);

  // R1
  idle_pins_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!convOut && !sckOut));

  // R12
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && state != ST_IDLE) |-> (pwrState == $past(pwrState)));

endmodule

// File: rtl/adcc_datapath.sv
module adcc_datapath
  import adcc_pkg::*;
#(
  parameter int WORD_BITS = 14,
  parameter int MAX_CH    = 6,
  localparam int CH_W     = $clog2(MAX_CH + 1),
  localparam int BIT_W    = $clog2(WORD_BITS),
  localparam int IDX_W    = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strb,
  input  logic [CH_W-1:0]             numChLat,
  input  logic                        sdoIn,
  output logic [MAX_CH*WORD_BITS-1:0] chData,
  output logic                        dataValid
);

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] stage [MAX_CH];
  logic [WORD_BITS-1:0] outWord [MAX_CH];
  logic [BIT_W-1:0]     bitCnt;
  logic [IDX_W-1:0]     chIdx;
  logic [WORD_BITS-1:0] newWord;
  logic                 wordDone;
  logic                 publish;

  always_comb begin
    newWord  = {shiftReg[WORD_BITS-2:0], sdoIn};
    wordDone = strb.sampleBit && (bitCnt == BIT_W'(WORD_BITS - 1));
    publish  = wordDone && (CH_W'(chIdx) == numChLat - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      chIdx    <= '0;
    end else if (strb.frameStart) begin
      bitCnt <= '0;
      chIdx  <= '0;
    end else if (strb.sampleBit) begin
      shiftReg <= newWord;
      if (wordDone) begin
        bitCnt <= '0;
        if (!publish) chIdx <= chIdx + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataValid <= 1'b0;
    else       dataValid <= publish;
  end

  generate
    for (genvar c = 0; c < MAX_CH; c++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[c] <= '0;
        end else if (wordDone && chIdx == IDX_W'(c)) begin
          stage[c] <= newWord;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outWord[c] <= '0;
        end else if (publish) begin
          if (IDX_W'(c) < chIdx)       outWord[c] <= stage[c];
          else if (IDX_W'(c) == chIdx) outWord[c] <= newWord;
          else                         outWord[c] <= '0;
        end
      end

      assign chData[c*WORD_BITS +: WORD_BITS] = outWord[c];
    end
  endgenerate

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chData) |-> dataValid);

  // R4
  chan_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    CH_W'(chIdx) < numChLat);

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adcc_pkg::*;
#(
  parameter int SCK_HALF       = 2,
  parameter int CONV_LOW_MIN   = 4,
  parameter int FRAME_EDGES    = 96,
  parameter int FIRST_EDGE     = 3,
  parameter int WORD_BITS      = 14,
  parameter int MAX_CH         = 6,
  parameter int GAP_W          = 16,
  parameter int SETTLE_W       = 20,
  parameter int SETTLE_DEFAULT = 500000,
  localparam int CH_W          = $clog2(MAX_CH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        runEn,
  input  logic [GAP_W-1:0]            frameGap,
  input  logic [CH_W-1:0]             numCh,
  input  logic                        modeReq,
  input  logic [1:0]                  modeSel,
  input  logic [SETTLE_W-1:0]         settleCycles,
  input  logic                        adcSdo,
  output logic                        adcConv,
  output logic                        adcSck,
  output logic [MAX_CH*WORD_BITS-1:0] chData,
  output logic                        dataValid,
  output logic                        busy,
  output logic [1:0]                  pwrState
);

  ctrlStrobe_t     strb;
  logic [CH_W-1:0] numChLat;
  pwr_e            pwrInt;

  adcc_ctrl #(
    .SCK_HALF(SCK_HALF), .CONV_LOW_MIN(CONV_LOW_MIN), .FRAME_EDGES(FRAME_EDGES),
    .FIRST_EDGE(FIRST_EDGE), .WORD_BITS(WORD_BITS), .MAX_CH(MAX_CH),
    .GAP_W(GAP_W), .SETTLE_W(SETTLE_W), .SETTLE_DEFAULT(SETTLE_DEFAULT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .frameGap(frameGap), .numCh(numCh),
    .modeReq(modeReq), .modeSel(modeSel), .settleCycles(settleCycles),
    .convOut(adcConv), .sckOut(adcSck), .busy(busy), .pwrState(pwrInt),
    .numChLat(numChLat), .strb(strb)
  );

  adcc_datapath #(
    .WORD_BITS(WORD_BITS), .MAX_CH(MAX_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .numChLat(numChLat), .sdoIn(adcSdo),
    .chData(chData), .dataValid(dataValid)
  );

  assign pwrState = pwrInt;

endmodule

// File: tb/adc_capture_ctrl_test.sv
module adc_capture_ctrl_test;

  localparam int H      = 2;
  localparam int LOWMIN = 6;
  localparam int WB     = 14;
  localparam int NCH    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [15:0] frameGap = 16'd0;
  logic [2:0] numCh = 3'd6;
  logic modeReq = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [19:0] settleCycles = 20'd100;
  logic adcSdo = 1'b1;
  logic adcConv, adcSck, dataValid, busy;
  logic [NCH*WB-1:0] chData;
  logic [1:0] pwrState;

  adc_capture_ctrl #(.SCK_HALF(H), .CONV_LOW_MIN(LOWMIN)) uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .frameGap(frameGap), .numCh(numCh),
    .modeReq(modeReq), .modeSel(modeSel), .settleCycles(settleCycles),
    .adcSdo(adcSdo), .adcConv(adcConv), .adcSck(adcSck), .chData(chData),
    .dataValid(dataValid), .busy(busy), .pwrState(pwrState)
  );

  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model and pin monitor, all at the falling clock edge
  logic [WB-1:0] words [NCH];
  logic prevConv = 1'b0, prevSck = 1'b0;
  int convRises = 0, sckRises = 0, convNoSck = 0, frameEdge = 0, winViol = 0;
  int validCount = 0;
  longint riseCyc = 0, fallCyc = 0, sckRiseCyc = 0;
  longint lastPeriod = 0, lastHigh = 0, lastLow = 0, lastSckHigh = 0;
  logic [NCH*WB-1:0] lastData = '0;

  always @(negedge clk) begin
    if (adcConv && !prevConv) begin
      if (frameEdge >= 2 && frameEdge < 96) winViol++;
      convRises++;
      convNoSck++;
      lastPeriod = cyc - riseCyc;
      lastLow    = cyc - fallCyc;
      riseCyc    = cyc;
      frameEdge  = 0;
    end
    if (!adcConv && prevConv) begin
      lastHigh = cyc - riseCyc;
      fallCyc  = cyc;
    end
    if (adcSck && !prevSck) begin
      sckRises++;
      convNoSck = 0;
      frameEdge++;
      sckRiseCyc = cyc;
      if (frameEdge >= 3 && frameEdge - 3 < NCH * WB)
        adcSdo = words[(frameEdge - 3) / WB][WB - 1 - ((frameEdge - 3) % WB)];
      else
        adcSdo = 1'b1;
    end
    if (!adcSck && prevSck) lastSckHigh = cyc - sckRiseCyc;
    if (dataValid) begin
      validCount++;
      lastData = chData;
    end
    prevConv = adcConv;
    prevSck  = adcSck;
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic setWords(input int seed);
    for (int c = 0; c < NCH; c++) words[c] = WB'(seed * 977 + c * 4099 + 16'h2A5B);
  endtask

  task automatic runFrames(input int n, input int chs, input int gap);
    int base;
    base = convRises;
    numCh = 3'(chs);
    frameGap = 16'(gap);
    runEn = 1'b1;
    while (convRises < base + n) @(negedge clk);
    runEn = 1'b0;
    waitIdle();
  endtask

  task automatic checkWords(input string tag, input int eff);
    for (int c = 0; c < NCH; c++)
      check(tag, longint'(lastData[c*WB +: WB]), (c < eff) ? longint'(words[c]) : 0);
  endtask

  task automatic sendMode(input logic [1:0] sel);
    modeSel = sel;
    modeReq = 1'b1;
    @(negedge clk);
    modeReq = 1'b0;
  endtask

  task automatic testReset();
    check("R14 conv", adcConv, 0);
    check("R14 sck", adcSck, 0);
    check("R14 busy", busy, 0);
    check("R14 valid", dataValid, 0);
    check("R14 data", longint'(chData == '0), 1);
    check("R14 pwr", pwrState, 0);
  endtask

  task automatic testFullFrames();
    int v0;
    setWords(1);
    v0 = validCount;
    runFrames(3, 6, 20);
    check("R1 conv high", lastHigh, 2 * H);
    check("R1 sck high", lastSckHigh, H);
    check("R2 edges per frame", frameEdge, 96);
    check("R2 no reconv", winViol, 0);
    check("R6 period", lastPeriod, 192 * H + 20 + 1);
    check("R5 valid count", validCount - v0, 3);
    checkWords("R3 words", 6);
  endtask

  task automatic testChannelCounts();
    int v0;
    setWords(2);
    runFrames(2, 2, 2);
    check("R6 gap floor", lastPeriod, 192 * H + LOWMIN + 1);
    checkWords("R4 two ch", 2);
    setWords(3);
    runFrames(1, 0, 8);
    checkWords("R4 zero as one", 1);
    setWords(4);
    runFrames(1, 7, 8);
    checkWords("R4 seven as six", 6);
    v0 = validCount;
    repeat (40) @(negedge clk);
    check("R5 hold data", longint'(chData == lastData), 1);
    check("R5 no extra valid", validCount - v0, 0);
  endtask

  task automatic testBusyIgnore();
    setWords(5);
    numCh = 3'd1;
    frameGap = 16'd8;
    runEn = 1'b1;
    while (!busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check("R12 busy in frame", busy, 1);
    sendMode(2'd1);
    runEn = 1'b0;
    waitIdle();
    repeat (20) @(negedge clk);
    check("R12 request dropped", pwrState, 0);
    check("R12 no pd pulses", longint'(convNoSck < 2), 1);
    checkWords("R12 capture intact", 1);
  endtask

  task automatic testIgnoredModes();
    int c0, s0;
    c0 = convRises;
    s0 = sckRises;
    sendMode(2'd0);
    sendMode(2'd3);
    repeat (20) @(negedge clk);
    check("R13 conv quiet", convRises - c0, 0);
    check("R13 sck quiet", sckRises - s0, 0);
    check("R13 pwr", pwrState, 0);
  endtask

  task automatic testNap();
    int c0, s0, j;
    sendMode(2'd1);
    waitIdle();
    check("R7 two pulses", convNoSck, 2);
    check("R7 pwr nap", pwrState, 1);
    check("R9 low between", lastLow, LOWMIN);
    check("R1 pd high", lastHigh, 2 * H);
    c0 = convRises;
    s0 = sckRises;
    runEn = 1'b1;
    sendMode(2'd2);
    repeat (60) @(negedge clk);
    runEn = 1'b0;
    check("R13 no frame in nap", convRises - c0, 0);
    check("R13 sleep ignored in nap", pwrState, 1);
    sendMode(2'd0);
    j = 1;
    while (pwrState != 2'd0 && j < 1000) begin
      @(negedge clk);
      j++;
    end
    check("R10 nap wake time", j, 2 * H + 1);
    check("R10 one sck", sckRises - s0, 1);
    check("R10 no conv", convRises - c0, 0);
  endtask

  task automatic testSleep();
    int c0, s0, j;
    sendMode(2'd2);
    waitIdle();
    check("R8 four pulses", convNoSck, 4);
    check("R8 pwr sleep", pwrState, 2);
    c0 = convRises;
    s0 = sckRises;
    sendMode(2'd0);
    j = 1;
    while (pwrState != 2'd0 && j < 1000) begin
      @(negedge clk);
      j++;
      if (j == 60) check("R11 still settling", pwrState, 2);
    end
    check("R11 sleep wake time", j, 2 * H + 100 + 1);
    check("R10 one sck sleep", sckRises - s0, 1);
    check("R10 no conv sleep", convRises - c0, 0);
    setWords(6);
    runFrames(1, 4, 8);
    checkWords("R3 after wake", 4);
  endtask

  initial begin
    setWords(0);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullFrames();
    testChannelCounts();
    testBusyIgnore();
    testIgnoredModes();
    testNap();
    testSleep();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule